// File: doc/BRIEF.md
# Embedded Sync Stream Decoder

This block sits on the receive side of a serial pixel link, after the bits have been recovered and framed into 10-bit words. It takes one word per clock, qualified by a valid strobe. The stream carries its timing in-band, and the block rebuilds a parallel pixel bus with a line-active flag and a frame-active flag. The lowest code values are reserved for control. A frame opens with a three-word marker made of the all-ones word, a zero word and the all-ones word again. Code 1 opens a line, code 2 closes a line, and code 3 closes both the line and the frame.

An all-ones word can be an ordinary pixel or the head of a frame marker, and only the word after it tells the two apart. The block therefore holds every word for one accepted word before it classifies it. The result then passes through one more register, so every accepted word produces exactly one output beat, two accepted words later. Beats that carry no pixel show zero data with the line flag low. When codes arrive in an illegal order, a sticky error flag is set and the decoder drops back to hunting for the next frame marker.

Top module: `esd_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid, line_valid, frame_valid, err_flag and pix_data are all zero.
- R2: Each word accepted with in_valid high produces exactly one output beat. The beat is out_valid high for one cycle, driven on the clock edge that accepts the second word after it. In a cycle with no accepted word, out_valid is low and pix_data, line_valid and frame_valid hold their values.
- R3: A word with a value of 4 or more that arrives while a line is open comes out as a pixel: pix_data equals the word, line_valid is 1 and frame_valid is 1. This includes the value 4, and the value 1023 when the next word is not 0.
- R4: A beat that is not a line pixel carries pix_data 0 and line_valid 0. Such beats are control words 0 to 3, frame-marker words, and words of value 4 or more outside a line. Inside a frame, filler between lines has frame_valid 1.
- R5: The sequence 1023, 0, 1023 is a frame marker. Its three beats have frame_valid 0, and the beats after it have frame_valid 1.
- R6: Code 1 inside a frame with no open line opens a line. Its own beat has line_valid 0 and frame_valid 1, and the pixel beats after it have line_valid 1.
- R7: Code 2 while a line is open closes the line. Its beat has line_valid 0 and frame_valid 1, and the frame stays open.
- R8: Code 3 while a line is open closes the line and the frame. Its beat has line_valid 0 and frame_valid 0, and later filler beats have frame_valid 0.
- R9: Each of the following is an order error: code 1 with a line open, code 2 or 3 with no line open, any of codes 1 to 3 outside a frame, a 0 that does not follow a marker head, a marker whose third word is not 1023, and a marker head inside an open frame. The error beat has line_valid 0 and frame_valid 0, err_flag rises with it, and later codes are ignored until the next frame marker.
- R10: Once set, err_flag stays high until reset. A correct frame marker after an error starts a frame that decodes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_word for this cycle |
| in_word | input | WORD_W (10) | Deserialized word with embedded codes |
| out_valid | output | 1 | One output beat this cycle |
| pix_data | output | WORD_W (10) | Pixel value, zero on non-pixel beats |
| line_valid | output | 1 | Rebuilt line-active flag |
| frame_valid | output | 1 | Rebuilt frame-active flag |
| err_flag | output | 1 | Sticky code-order error |

## Verification
The bench targets the word 1023 used as a pixel just before code 3. A decoder that looks at the value alone would swallow that pixel or take it for a marker head. It also sends the pixel value 4, which a decoder that treats all small values as codes would drop. Gaps in in_valid are checked so that a pipeline that advances on the clock instead of on accepted words would show extra or early beats. Each order error is driven on its own: a repeated code 1, codes 2 and 3 with no line, a line code outside a frame, a broken marker and a marker in the middle of a frame. These catch a decoder that keeps frame_valid up after an error, clears the sticky flag, or fails to start again on the next marker.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int unsigned ESD_NUM_CODES = 4;

  typedef enum logic [2:0] {
    K_PIX,
    K_C0,
    K_C1,
    K_C2,
    K_C3,
    K_HEAD
  } esd_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HEAD,
    PH_ZERO
  } esd_phase_e;
endpackage

// File: rtl/esd_classify.sv
module esd_classify
  import esd_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] nxt,
  output esd_kind_e         kind
);
  localparam logic [WORD_W-1:0] MAXV  = '1;
  localparam logic [WORD_W-1:0] CODES = WORD_W'(ESD_NUM_CODES);

  always_comb begin
    kind = K_PIX;
    if (cur < CODES) begin
      case (cur[1:0])
        2'd0:    kind = K_C0;
        2'd1:    kind = K_C1;
        2'd2:    kind = K_C2;
        default: kind = K_C3;
      endcase
    end else if (cur == MAXV && nxt == '0) begin
      kind = K_HEAD;
    end
  end
endmodule

// File: rtl/esd_tracker.sv
module esd_tracker
  import esd_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              cur_vld,
  input  logic [WORD_W-1:0] cur,
  input  esd_kind_e         kind,
  output logic              mid_vld,
  output logic [WORD_W-1:0] mid_data,
  output logic              mid_lv,
  output logic              mid_fv,
  output logic              mid_err
);
  localparam logic [WORD_W-1:0] MAXV = '1;

  logic       in_frame, in_line;
  esd_phase_e phase;

  logic       nx_frame, nx_line;
  esd_phase_e nx_phase;
  logic       b_lv, b_fv, b_pix, b_err;

  always_comb begin
    nx_frame = in_frame;
    nx_line  = in_line;
    nx_phase = phase;
    b_lv     = 1'b0;
    b_fv     = in_frame;
    b_pix    = 1'b0;
    b_err    = 1'b0;
    if (phase == PH_ZERO) begin
      nx_phase = PH_IDLE;
      b_fv     = 1'b0;
      if (cur == MAXV) begin
        nx_frame = 1'b1;
        nx_line  = 1'b0;
      end else begin
        b_err = 1'b1;
      end
    end else if (phase == PH_HEAD) begin
      nx_phase = PH_ZERO;
      b_fv     = 1'b0;
    end else begin
      case (kind)
        K_HEAD: begin
          nx_phase = PH_HEAD;
          b_fv     = 1'b0;
          if (in_frame) b_err = 1'b1;
        end
        K_C0: b_err = 1'b1;
        K_C1: begin
          if (in_frame && !in_line) nx_line = 1'b1;
          else                      b_err   = 1'b1;
        end
        K_C2: begin
          if (in_line) nx_line = 1'b0;
          else         b_err   = 1'b1;
        end
        K_C3: begin
          if (in_line) begin
            nx_line  = 1'b0;
            nx_frame = 1'b0;
            b_fv     = 1'b0;
          end else begin
            b_err = 1'b1;
          end
        end
        default: begin
          if (in_line) begin
            b_lv  = 1'b1;
            b_pix = 1'b1;
          end
        end
      endcase
    end
    if (b_err) begin
      nx_frame = 1'b0;
      nx_line  = 1'b0;
      b_fv     = 1'b0;
      b_lv     = 1'b0;
      b_pix    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      in_line  <= 1'b0;
      phase    <= PH_IDLE;
      mid_vld  <= 1'b0;
      mid_data <= '0;
      mid_lv   <= 1'b0;
      mid_fv   <= 1'b0;
      mid_err  <= 1'b0;
    end else if (adv) begin
      mid_vld <= cur_vld;
      if (cur_vld) begin
        in_frame <= nx_frame;
        in_line  <= nx_line;
        phase    <= nx_phase;
        mid_data <= b_pix ? cur : '0;
        mid_lv   <= b_lv;
        mid_fv   <= b_fv;
        mid_err  <= b_err;
      end
    end
  end
endmodule

// File: rtl/esd_out_stage.sv
module esd_out_stage #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              mid_vld,
  input  logic [WORD_W-1:0] mid_data,
  input  logic              mid_lv,
  input  logic              mid_fv,
  input  logic              mid_err,
  output logic              out_valid,
  output logic [WORD_W-1:0] pix_data,
  output logic              line_valid,
  output logic              frame_valid,
  output logic              err_flag
);
  logic fire;
  assign fire = adv && mid_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      pix_data    <= '0;
      line_valid  <= 1'b0;
      frame_valid <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        pix_data    <= mid_data;
        line_valid  <= mid_lv;
        frame_valid <= mid_fv;
        if (mid_err) err_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/esd_decoder.sv
module esd_decoder
  import esd_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] pix_data,
  output logic              line_valid,
  output logic              frame_valid,
  output logic              err_flag
);
  logic [WORD_W-1:0] hold_word;
  logic              hold_vld;
  esd_kind_e         kind;
  logic              mid_vld, mid_lv, mid_fv, mid_err;
  logic [WORD_W-1:0] mid_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word <= '0;
      hold_vld  <= 1'b0;
    end else if (in_valid) begin
      hold_word <= in_word;
      hold_vld  <= 1'b1;
    end
  end

  esd_classify #(.WORD_W(WORD_W)) u_cls (
    .cur  (hold_word),
    .nxt  (in_word),
    .kind (kind)
  );

  esd_tracker #(.WORD_W(WORD_W)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .adv      (in_valid),
    .cur_vld  (hold_vld),
    .cur      (hold_word),
    .kind     (kind),
    .mid_vld  (mid_vld),
    .mid_data (mid_data),
    .mid_lv   (mid_lv),
    .mid_fv   (mid_fv),
    .mid_err  (mid_err)
  );

  esd_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .adv         (in_valid),
    .mid_vld     (mid_vld),
    .mid_data    (mid_data),
    .mid_lv      (mid_lv),
    .mid_fv      (mid_fv),
    .mid_err     (mid_err),
    .out_valid   (out_valid),
    .pix_data    (pix_data),
    .line_valid  (line_valid),
    .frame_valid (frame_valid),
    .err_flag    (err_flag)
  );
endmodule

// File: rtl/esd_decoder_checker.sv
module esd_decoder_checker #(
  parameter int unsigned WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [WORD_W-1:0] pix_data,
  input logic              line_valid,
  input logic              frame_valid,
  input logic              err_flag
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !line_valid && !frame_valid && !err_flag && pix_data == '0));

  a_r2_no_beat_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(pix_data) && $stable(line_valid) && $stable(frame_valid)));

  a_r3_pixel_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && line_valid) |-> (pix_data >= WORD_W'(4) && frame_valid));

  a_r4_nonpixel_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !line_valid) |-> (pix_data == '0));

  a_r9_err_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> (out_valid && !line_valid && !frame_valid));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
endmodule

bind esd_decoder esd_decoder_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .pix_data    (pix_data),
  .line_valid  (line_valid),
  .frame_valid (frame_valid),
  .err_flag    (err_flag)
);

// File: tb/esd_decoder_tb.sv
`timescale 1ns/1ps
module esd_decoder_tb;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         out_valid, line_valid, frame_valid, err_flag;
  logic [W-1:0] pix_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic [W-1:0] m_d[$];
  bit           m_lv[$], m_fv[$];
  logic [W-1:0] e_d[$];
  bit           e_lv[$], e_fv[$];

  always #2 clk = ~clk;

  esd_decoder #(.WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .pix_data(pix_data), .line_valid(line_valid),
    .frame_valid(frame_valid), .err_flag(err_flag)
  );

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      m_d.push_back(pix_data);
      m_lv.push_back(line_valid);
      m_fv.push_back(frame_valid);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    m_d.delete(); m_lv.delete(); m_fv.delete();
    e_d.delete(); e_lv.delete(); e_fv.delete();
    rst = 1'b0;
  endtask

  task automatic feed(input int w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = W'(w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic ex(input int d, input bit lv, input bit fv);
    e_d.push_back(W'(d));
    e_lv.push_back(lv);
    e_fv.push_back(fv);
  endtask

  task automatic ex_marker();
    ex(0, 0, 0); ex(0, 0, 0); ex(0, 0, 0);
  endtask

  task automatic marker();
    feed(1023); feed(0); feed(1023);
  endtask

  // Two flush words push every real beat out; their own beats stay inside.
  task automatic finish_seq(input string req, input bit err_exp);
    feed(5); feed(5);
    idle(3);
    chk(m_d.size() == e_d.size(), req, "beat count", m_d.size(), e_d.size());
    for (int i = 0; i < e_d.size() && i < m_d.size(); i++) begin
      chk(m_d[i] == e_d[i] && m_lv[i] == e_lv[i] && m_fv[i] == e_fv[i], req,
          $sformatf("beat %0d {data,lv,fv}", i),
          int'({m_d[i], m_lv[i], m_fv[i]}), int'({e_d[i], e_lv[i], e_fv[i]}));
    end
    chk(err_flag == err_exp, req, "err_flag", err_flag, err_exp);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(!out_valid && !line_valid && !frame_valid, "R1", "flags after reset",
        int'({out_valid, line_valid, frame_valid}), 0);
    chk(!err_flag && pix_data == '0, "R1", "err/data after reset",
        int'({err_flag, pix_data}), 0);
  endtask

  // R3 R4 R5 R6 R7 R8: two lines, filler, value 4, 1023 pixel before code 3
  task automatic t_normal_frame();
    do_reset();
    marker(); ex_marker();
    feed(1);  ex(0, 0, 1);
    feed(10); ex(10, 1, 1);
    feed(11); ex(11, 1, 1);
    feed(12); ex(12, 1, 1);
    feed(2);  ex(0, 0, 1);
    feed(99); ex(0, 0, 1);
    feed(1);  ex(0, 0, 1);
    feed(20); ex(20, 1, 1);
    feed(4);  ex(4, 1, 1);
    feed(1023); ex(1023, 1, 1);
    feed(3);  ex(0, 0, 0);
    feed(77); ex(0, 0, 0);
    finish_seq("R3/R4/R5/R6/R7/R8", 1'b0);
  endtask

  // R2: beats advance on accepted words only, outputs hold during gaps
  task automatic t_latency_stall();
    do_reset();
    marker(); feed(1); feed(40);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && !frame_valid, "R2", "marker tail beat after accept of 40",
        int'({out_valid, frame_valid}), 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!out_valid, "R2", "no beat without accept", out_valid, 0);
    end
    in_valid = 1'b1;
    in_word  = W'(41);
    @(negedge clk);
    chk(out_valid && !line_valid && frame_valid && pix_data == '0, "R2",
        "code 1 beat on accept of 41", int'({out_valid, line_valid, frame_valid}), 5);
    in_word = W'(42);
    @(negedge clk);
    chk(out_valid && line_valid && pix_data == W'(40), "R2",
        "pixel 40 beat on accept of 42", int'(pix_data), 40);
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid && line_valid && frame_valid && pix_data == W'(40), "R2",
        "outputs hold in gap", int'(pix_data), 40);
  endtask

  // R9 R10: line code outside a frame, then recovery on the next marker
  task automatic t_err_outside();
    do_reset();
    feed(50); ex(0, 0, 0);
    feed(1);  ex(0, 0, 0);
    feed(12); ex(0, 0, 0);
    marker(); ex_marker();
    feed(1);  ex(0, 0, 1);
    feed(7);  ex(7, 1, 1);
    feed(3);  ex(0, 0, 0);
    finish_seq("R9/R10", 1'b1);
  endtask

  // R9: code 1 while a line is open, later code 3 ignored while hunting
  task automatic t_err_double_open();
    do_reset();
    marker(); ex_marker();
    feed(1); ex(0, 0, 1);
    feed(9); ex(9, 1, 1);
    feed(1); ex(0, 0, 0);
    feed(8); ex(0, 0, 0);
    feed(3); ex(0, 0, 0);
    finish_seq("R9", 1'b1);
  endtask

  // R9: code 2 and code 3 with no open line
  task automatic t_err_no_line();
    do_reset();
    marker(); ex_marker();
    feed(2);  ex(0, 0, 0);
    feed(60); ex(0, 0, 0);
    finish_seq("R9 code2", 1'b1);
    do_reset();
    marker(); ex_marker();
    feed(3);  ex(0, 0, 0);
    feed(60); ex(0, 0, 0);
    finish_seq("R9 code3", 1'b1);
  endtask

  // R9: broken marker, stray zero
  task automatic t_err_bad_marker();
    do_reset();
    feed(1023); ex(0, 0, 0);
    feed(0);    ex(0, 0, 0);
    feed(7);    ex(0, 0, 0);
    feed(1);    ex(0, 0, 0);
    feed(8);    ex(0, 0, 0);
    finish_seq("R9 marker", 1'b1);
    do_reset();
    feed(30); ex(0, 0, 0);
    feed(0);  ex(0, 0, 0);
    finish_seq("R9 stray zero", 1'b1);
  endtask

  // R9 R10: marker inside an open frame restarts the frame
  task automatic t_err_marker_in_frame();
    do_reset();
    marker(); ex_marker();
    feed(1); ex(0, 0, 1);
    feed(5); ex(5, 1, 1);
    marker(); ex_marker();
    feed(1); ex(0, 0, 1);
    feed(6); ex(6, 1, 1);
    feed(3); ex(0, 0, 0);
    finish_seq("R9/R10 restart", 1'b1);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_normal_frame();
    t_latency_stall();
    t_err_outside();
    t_err_double_open();
    t_err_no_line();
    t_err_bad_marker();
    t_err_marker_in_frame();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule